// File: doc/BRIEF.md
# Multi-Core Interrupt Distributor

This block gathers the interrupt sources of a small multi-core cluster and decides, for every CPU, which one interrupt that CPU should service next. The ID space is split into three classes. IDs 0 to 15 are software-raised events. IDs 16 to 31 are private per-CPU peripheral lines. IDs 32 and upward are shared peripheral lines. The block stores an enable and an 8-bit priority for every ID. It also stores pending and active state: one copy per CPU for the first two classes, and one copy shared by all CPUs for the shared lines. Each shared line also has a CPU routing mask.

Every CPU interface sees a registered offer: a valid flag, an ID and the priority of the best candidate for that CPU. A CPU takes the offered interrupt by pulsing its acknowledge. It ends service with an end-of-service pulse that carries the ID. Software-raised events are handled independently on each CPU. A shared line is claimed by the first CPU that acknowledges it and is then withdrawn from every other CPU. A configuration write port sets the global enable, the per-ID enables, the priorities and the routing masks. A separate request port raises software events on a chosen set of CPUs.

Top module: `irq_dist`

## Requirements
- R1: After reset every output valid flag is 0, the global enable and all per-ID enables are off, all priorities and routing masks are 0, and no pending or active state is held.
- R2: While the global enable is 0, no CPU is offered any interrupt. Pending state is still collected and is offered once the global enable is set.
- R3: An ID whose enable is 0 is never offered. Its pending state is kept and it is offered again when it is re-enabled.
- R4: Each CPU is offered the candidate with the numerically smallest 8-bit priority, with a tie going to the lower ID. The offer appears one clock after the state change that causes it.
- R5: A software request with a 4-bit ID and a CPU list sets that ID pending on every CPU c whose list bit c is 1, and on no other CPU.
- R6: Acknowledging a software-raised ID on one CPU clears its pending state on that CPU only. The same ID stays pending on the other CPUs.
- R7: Private line bit c*16+(id-16) of `ppi_i` sets pending for that ID on CPU c only.
- R8: A shared ID is offered only to the CPUs whose bit is 1 in its routing mask (bit c = CPU c). Routing writes to IDs below 32 have no effect.
- R9: Acknowledging a shared ID on any CPU clears its single pending bit, so no CPU is offered it afterwards. When several CPUs acknowledge it in the same cycle, it is claimed once.
- R10: An acknowledged ID becomes active and is not offered again until an end-of-service for that ID arrives. While a peripheral ID is active, a high input does not make it pending. If the input is still high after the end-of-service, it becomes pending again.
- R11: An acknowledge takes effect only when the CPU's valid flag is 1 and the offered ID is still a live candidate in that cycle. A stale or unoffered acknowledge changes nothing.
- R12: A configuration write uses `cfg_kind_i` 0 for the global enable (data bit 0), 1 for the per-ID enable (data bit 0), 2 for the priority (all 8 data bits) and 3 for the routing mask (low NUM_CPUS data bits), addressed by `cfg_id_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Configuration target: 0 global, 1 enable, 2 priority, 3 routing |
| cfg_id_i | input | 6 | ID addressed by the write |
| cfg_wdata_i | input | 8 | Write data |
| sgi_req_i | input | 1 | Software event request strobe |
| sgi_id_i | input | 4 | Software event ID (0 to 15) |
| sgi_cpus_i | input | 2 | CPU list of the request |
| ppi_i | input | 32 | Private peripheral levels, 16 per CPU |
| spi_i | input | 32 | Shared peripheral levels for IDs 32 to 63 |
| ack_i | input | 2 | Per-CPU acknowledge of the offered ID |
| eoi_i | input | 2 | Per-CPU end-of-service strobe |
| eoi_id_i | input | 12 | Per-CPU end-of-service ID, 6 bits each |
| irq_valid_o | output | 2 | Per-CPU offer valid |
| irq_id_o | output | 12 | Per-CPU offered ID, 6 bits each |
| irq_prio_o | output | 16 | Per-CPU offered priority, 8 bits each |

## Verification
The selection is tried in four situations. Two IDs share a priority, which shows whether ties go to the lower ID. A lower-valued priority is written later to the higher ID, which shows whether the numeric compare is used rather than order of arrival. Two shared IDs have priorities 0xFE and 0xFF, which exposes a truncated compare. Software events raised on different CPU lists, followed by acknowledges on one CPU, tell per-CPU pending apart from shared pending. A shared line routed to both CPUs and acknowledged by one or both shows whether the claim withdraws the offer everywhere. A held-high private line across acknowledge and end-of-service, and an acknowledge held one cycle past its offer, show whether active state blocks re-pending and whether stale acknowledges are refused.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

   localparam int SGI_NUM  = 16;
   localparam int PPI_BASE = 16;
   localparam int PPI_NUM  = 16;
   localparam int SPI_BASE = 32;

   typedef enum logic [1:0] {
      CFG_GLOBAL = 2'd0,
      CFG_ENABLE = 2'd1,
      CFG_PRIO   = 2'd2,
      CFG_TARGET = 2'd3
   } cfg_kind_e;

endpackage

// File: rtl/irq_dist_select.sv
module irq_dist_select #(
   parameter int NUM_IDS = 64,
   parameter int PRIO_W  = 8,
   localparam int ID_W   = $clog2(NUM_IDS)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NUM_IDS-1:0]             cand_i,
   input  logic [NUM_IDS-1:0][PRIO_W-1:0] prio_i,
   output logic                           valid_o,
   output logic [ID_W-1:0]                id_o,
   output logic [PRIO_W-1:0]              prio_o
);

   logic              found;
   logic [ID_W-1:0]   best_id;
   logic [PRIO_W-1:0] best_p;

   // ascending scan, strict compare keeps the lower ID on a tie
   always_comb begin
      found   = 1'b0;
      best_id = '0;
      best_p  = '1;
      for (int i = 0; i < NUM_IDS; i++) begin
         if (cand_i[i] && (!found || prio_i[i] < best_p)) begin
            found   = 1'b1;
            best_p  = prio_i[i];
            best_id = ID_W'(i);
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         id_o    <= '0;
         prio_o  <= '0;
      end else begin
         valid_o <= found;
         id_o    <= best_id;
         prio_o  <= best_p;
      end
   end

   AST_NO_CAND_NO_OFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|cand_i) |=> !valid_o); // R4
   AST_CAND_GIVES_OFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|cand_i) |=> valid_o); // R4

endmodule

// File: rtl/irq_dist_state.sv
module irq_dist_state
   import irq_dist_pkg::*;
#(
   parameter int NUM_CPUS = 2,
   parameter int NUM_IDS  = 64,
   parameter int PRIO_W   = 8,
   localparam int ID_W    = $clog2(NUM_IDS),
   localparam int NUM_SPI = NUM_IDS - SPI_BASE,
   localparam int BANK    = SPI_BASE,
   localparam int BANK_W  = $clog2(BANK)
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            cfg_we_i,
   input  logic [1:0]                      cfg_kind_i,
   input  logic [ID_W-1:0]                 cfg_id_i,
   input  logic [PRIO_W-1:0]               cfg_wdata_i,
   input  logic                            sgi_req_i,
   input  logic [3:0]                      sgi_id_i,
   input  logic [NUM_CPUS-1:0]             sgi_cpus_i,
   input  logic [NUM_CPUS*PPI_NUM-1:0]     ppi_i,
   input  logic [NUM_SPI-1:0]              spi_i,
   input  logic [NUM_CPUS-1:0]             ack_i,
   input  logic [NUM_CPUS-1:0]             valid_i,
   input  logic [NUM_CPUS-1:0][ID_W-1:0]   ack_id_i,
   input  logic [NUM_CPUS-1:0]             eoi_i,
   input  logic [NUM_CPUS-1:0][ID_W-1:0]   eoi_id_i,
   output logic [NUM_CPUS-1:0][NUM_IDS-1:0] cand_o,
   output logic [NUM_IDS-1:0][PRIO_W-1:0]  prio_o
);

   logic                              dist_en_q;
   logic [NUM_IDS-1:0]                en_q;
   logic [NUM_IDS-1:0][PRIO_W-1:0]    prio_q;
   logic [NUM_SPI-1:0][NUM_CPUS-1:0]  tgt_q;
   logic [NUM_CPUS-1:0][BANK-1:0]     bpend_q, bpend_d, bact_q, bact_d;
   logic [NUM_SPI-1:0]                spend_q, spend_d, sact_q, sact_d;
   logic [NUM_CPUS-1:0]               ack_ok, take;

   // configuration registers
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         dist_en_q <= 1'b0;
         en_q      <= '0;
         prio_q    <= '0;
         tgt_q     <= '0;
      end else if (cfg_we_i) begin
         case (cfg_kind_i)
            CFG_GLOBAL: dist_en_q <= cfg_wdata_i[0];
            CFG_ENABLE: begin
               for (int i = 0; i < NUM_IDS; i++)
                  if (cfg_id_i == ID_W'(i)) en_q[i] <= cfg_wdata_i[0];
            end
            CFG_PRIO: begin
               for (int i = 0; i < NUM_IDS; i++)
                  if (cfg_id_i == ID_W'(i)) prio_q[i] <= cfg_wdata_i;
            end
            CFG_TARGET: begin
               for (int j = 0; j < NUM_SPI; j++)
                  if (cfg_id_i == ID_W'(SPI_BASE + j)) tgt_q[j] <= cfg_wdata_i[NUM_CPUS-1:0];
            end
            default: ;
         endcase
      end
   end

   // acknowledge qualification and shared-claim arbitration (lower CPU wins)
   always_comb begin
      for (int c = 0; c < NUM_CPUS; c++)
         ack_ok[c] = ack_i[c] & valid_i[c] & cand_o[c][ack_id_i[c]];
      take = ack_ok;
      for (int c = 1; c < NUM_CPUS; c++)
         for (int o = 0; o < c; o++)
            if (ack_ok[o] && ack_id_i[o] == ack_id_i[c] && ack_id_i[c] >= ID_W'(SPI_BASE))
               take[c] = 1'b0;
   end

   // pending / active next state
   always_comb begin
      logic set, clr, fin;
      bpend_d = bpend_q;
      bact_d  = bact_q;
      spend_d = spend_q;
      sact_d  = sact_q;
      for (int c = 0; c < NUM_CPUS; c++) begin
         for (int k = 0; k < SGI_NUM; k++) begin
            set = sgi_req_i && sgi_id_i == 4'(k) && sgi_cpus_i[c];
            clr = take[c] && ack_id_i[c] == ID_W'(k);
            fin = eoi_i[c] && eoi_id_i[c] == ID_W'(k);
            bpend_d[c][k] = (bpend_q[c][k] | set) & ~clr;
            bact_d[c][k]  = (bact_q[c][k] | clr) & ~fin;
         end
         for (int k = PPI_BASE; k < BANK; k++) begin
            set = ppi_i[c*PPI_NUM + k - PPI_BASE] && !bact_q[c][k];
            clr = take[c] && ack_id_i[c] == ID_W'(k);
            fin = eoi_i[c] && eoi_id_i[c] == ID_W'(k);
            bpend_d[c][k] = (bpend_q[c][k] | set) & ~clr;
            bact_d[c][k]  = (bact_q[c][k] | clr) & ~fin;
         end
      end
      for (int j = 0; j < NUM_SPI; j++) begin
         clr = 1'b0;
         fin = 1'b0;
         for (int c = 0; c < NUM_CPUS; c++) begin
            clr = clr | (take[c] && ack_id_i[c] == ID_W'(SPI_BASE + j));
            fin = fin | (eoi_i[c] && eoi_id_i[c] == ID_W'(SPI_BASE + j));
         end
         set        = spi_i[j] && !sact_q[j];
         spend_d[j] = (spend_q[j] | set) & ~clr;
         sact_d[j]  = (sact_q[j] | clr) & ~fin;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         bpend_q <= '0;
         bact_q  <= '0;
         spend_q <= '0;
         sact_q  <= '0;
      end else begin
         bpend_q <= bpend_d;
         bact_q  <= bact_d;
         spend_q <= spend_d;
         sact_q  <= sact_d;
      end
   end

   assign prio_o = prio_q;

   // candidate vectors: banked or shared storage per ID
   for (genvar gc = 0; gc < NUM_CPUS; gc++) begin : g_cpu
      for (genvar gk = 0; gk < NUM_IDS; gk++) begin : g_id
         if (gk < BANK) begin : g_banked
            assign cand_o[gc][gk] = dist_en_q & en_q[gk] & bpend_q[gc][gk] & ~bact_q[gc][gk];
         end else begin : g_shared
            assign cand_o[gc][gk] = dist_en_q & en_q[gk] & spend_q[gk-BANK] &
                                    ~sact_q[gk-BANK] & tgt_q[gk-BANK][gc];
         end
      end

      AST_SPI_CLAIM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (take[gc] && ack_id_i[gc] >= ID_W'(SPI_BASE))
         |=> !spend_q[$past(ack_id_i[gc]) - ID_W'(SPI_BASE)]); // R9

      for (genvar go = 0; go < NUM_CPUS; go++) begin : g_other
         if (go != gc) begin : g_diff
            AST_SGI_OTHER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
               (take[gc] && ack_id_i[gc] < ID_W'(SGI_NUM) &&
                bpend_q[go][ack_id_i[gc][BANK_W-1:0]] &&
                !(take[go] && ack_id_i[go] == ack_id_i[gc]))
               |=> bpend_q[go][$past(ack_id_i[gc][BANK_W-1:0])]); // R6
         end
      end

      for (genvar gp = PPI_BASE; gp < BANK; gp++) begin : g_ppi_chk
         AST_ACTIVE_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bact_q[gc][gp] && !bpend_q[gc][gp] && !(eoi_i[gc] && eoi_id_i[gc] == ID_W'(gp)))
            |=> !bpend_q[gc][gp]); // R10
      end
   end

endmodule

// File: rtl/irq_dist.sv
module irq_dist
   import irq_dist_pkg::*;
#(
   parameter int  NUM_CPUS = 2,
   parameter int  NUM_IDS  = 64,
   parameter int  PRIO_W   = 8,
   localparam int ID_W     = $clog2(NUM_IDS)
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          cfg_we_i,
   input  logic [1:0]                    cfg_kind_i,
   input  logic [ID_W-1:0]               cfg_id_i,
   input  logic [PRIO_W-1:0]             cfg_wdata_i,
   input  logic                          sgi_req_i,
   input  logic [3:0]                    sgi_id_i,
   input  logic [NUM_CPUS-1:0]           sgi_cpus_i,
   input  logic [NUM_CPUS*PPI_NUM-1:0]   ppi_i,
   input  logic [NUM_IDS-SPI_BASE-1:0]   spi_i,
   input  logic [NUM_CPUS-1:0]           ack_i,
   input  logic [NUM_CPUS-1:0]           eoi_i,
   input  logic [NUM_CPUS*ID_W-1:0]      eoi_id_i,
   output logic [NUM_CPUS-1:0]           irq_valid_o,
   output logic [NUM_CPUS*ID_W-1:0]      irq_id_o,
   output logic [NUM_CPUS*PRIO_W-1:0]    irq_prio_o
);

   if (NUM_IDS <= SPI_BASE || NUM_IDS > 1020) begin : g_bad_ids
      $error("irq_dist: NUM_IDS must lie in 33..1020");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > PRIO_W) begin : g_bad_cpus
      $error("irq_dist: NUM_CPUS must lie in 1..PRIO_W");
   end

   logic [NUM_CPUS-1:0][NUM_IDS-1:0]  cand;
   logic [NUM_IDS-1:0][PRIO_W-1:0]    prio;
   logic [NUM_CPUS-1:0][ID_W-1:0]     sel_id;
   logic [NUM_CPUS-1:0][PRIO_W-1:0]   sel_prio;

   irq_dist_state #(
      .NUM_CPUS (NUM_CPUS),
      .NUM_IDS  (NUM_IDS),
      .PRIO_W   (PRIO_W)
   ) u_state (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i),
      .cfg_kind_i  (cfg_kind_i),
      .cfg_id_i    (cfg_id_i),
      .cfg_wdata_i (cfg_wdata_i),
      .sgi_req_i   (sgi_req_i),
      .sgi_id_i    (sgi_id_i),
      .sgi_cpus_i  (sgi_cpus_i),
      .ppi_i       (ppi_i),
      .spi_i       (spi_i),
      .ack_i       (ack_i),
      .valid_i     (irq_valid_o),
      .ack_id_i    (sel_id),
      .eoi_i       (eoi_i),
      .eoi_id_i    (eoi_id_i),
      .cand_o      (cand),
      .prio_o      (prio)
   );

   for (genvar gc = 0; gc < NUM_CPUS; gc++) begin : g_sel
      irq_dist_select #(
         .NUM_IDS (NUM_IDS),
         .PRIO_W  (PRIO_W)
      ) u_sel (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .cand_i  (cand[gc]),
         .prio_i  (prio),
         .valid_o (irq_valid_o[gc]),
         .id_o    (sel_id[gc]),
         .prio_o  (sel_prio[gc])
      );
   end

   assign irq_id_o   = sel_id;
   assign irq_prio_o = sel_prio;

endmodule

// File: tb/irq_dist_tb.sv
module irq_dist_tb;

   localparam int NC = 2;
   localparam int NI = 64;
   localparam int PW = 8;
   localparam int IW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_kind = '0;
   logic [IW-1:0]   cfg_id = '0;
   logic [PW-1:0]   cfg_wdata = '0;
   logic            sgi_req = 1'b0;
   logic [3:0]      sgi_id = '0;
   logic [NC-1:0]   sgi_cpus = '0;
   logic [NC*16-1:0] ppi = '0;
   logic [NI-33:0]  spi = '0;
   logic [NC-1:0]   ack = '0;
   logic [NC-1:0]   eoi = '0;
   logic [NC*IW-1:0] eoi_id = '0;
   logic [NC-1:0]   irq_valid;
   logic [NC*IW-1:0] irq_id;
   logic [NC*PW-1:0] irq_prio;

   int n_tests = 0;
   int n_fail  = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   irq_dist u_dut (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind),
      .cfg_id_i(cfg_id), .cfg_wdata_i(cfg_wdata), .sgi_req_i(sgi_req),
      .sgi_id_i(sgi_id), .sgi_cpus_i(sgi_cpus), .ppi_i(ppi), .spi_i(spi),
      .ack_i(ack), .eoi_i(eoi), .eoi_id_i(eoi_id), .irq_valid_o(irq_valid),
      .irq_id_o(irq_id), .irq_prio_o(irq_prio)
   );

   // ---------------- behavioural reference model ----------------
   bit m_glb;
   bit m_en [NI];
   int m_prio [NI];
   int m_tgt [NI];
   bit m_bp [NC][32];
   bit m_ba [NC][32];
   bit m_sp [NI];
   bit m_sa [NI];
   bit e_v [NC];
   int e_id [NC];
   int e_pr [NC];

   function automatic bit mc(int c, int k);
      if (!m_glb || !m_en[k]) return 1'b0;
      if (k < 32) return m_bp[c][k] && !m_ba[c][k];
      return m_sp[k] && !m_sa[k] && (((m_tgt[k] >> c) & 1) == 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_glb = 0;
         for (int k = 0; k < NI; k++) begin
            m_en[k] = 0; m_prio[k] = 0; m_tgt[k] = 0; m_sp[k] = 0; m_sa[k] = 0;
         end
         for (int c = 0; c < NC; c++) begin
            e_v[c] = 0; e_id[c] = 0; e_pr[c] = 0;
            for (int k = 0; k < 32; k++) begin m_bp[c][k] = 0; m_ba[c][k] = 0; end
         end
      end else begin
         bit nv [NC];
         int nid [NC];
         int np [NC];
         bit tk [NC];
         for (int c = 0; c < NC; c++) begin
            int bestp;
            bestp = 1 << PW; nv[c] = 0; nid[c] = 0; np[c] = 0;
            for (int k = 0; k < NI; k++)
               if (mc(c, k) && m_prio[k] < bestp) begin
                  bestp = m_prio[k]; nv[c] = 1; nid[c] = k; np[c] = m_prio[k];
               end
            tk[c] = ack[c] && e_v[c] && mc(c, e_id[c]);
         end
         for (int c = 1; c < NC; c++)
            for (int o = 0; o < c; o++)
               if (tk[o] && tk[c] && e_id[o] == e_id[c] && e_id[c] >= 32) tk[c] = 0;
         for (int c = 0; c < NC; c++)
            for (int k = 0; k < 32; k++) begin
               bit s, cl, f;
               if (k < 16) s = sgi_req && int'(sgi_id) == k && sgi_cpus[c];
               else        s = ppi[c*16 + k - 16] && !m_ba[c][k];
               cl = tk[c] && e_id[c] == k;
               f  = eoi[c] && int'(eoi_id[c*IW +: IW]) == k;
               m_bp[c][k] = (m_bp[c][k] || s) && !cl;
               m_ba[c][k] = (m_ba[c][k] || cl) && !f;
            end
         for (int k = 32; k < NI; k++) begin
            bit s, cl, f;
            cl = 0; f = 0;
            for (int c = 0; c < NC; c++) begin
               if (tk[c] && e_id[c] == k) cl = 1;
               if (eoi[c] && int'(eoi_id[c*IW +: IW]) == k) f = 1;
            end
            s = spi[k-32] && !m_sa[k];
            m_sp[k] = (m_sp[k] || s) && !cl;
            m_sa[k] = (m_sa[k] || cl) && !f;
         end
         if (cfg_we) begin
            case (int'(cfg_kind))
               0: m_glb = cfg_wdata[0];
               1: m_en[int'(cfg_id)] = cfg_wdata[0];
               2: m_prio[int'(cfg_id)] = int'(cfg_wdata);
               default: if (int'(cfg_id) >= 32) m_tgt[int'(cfg_id)] = int'(cfg_wdata) & ((1 << NC) - 1);
            endcase
         end
         for (int c = 0; c < NC; c++) begin
            e_v[c] = nv[c]; e_id[c] = nid[c]; e_pr[c] = np[c];
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NC; c++) begin
            int aid, ap;
            aid = int'(irq_id[c*IW +: IW]);
            ap  = int'(irq_prio[c*PW +: PW]);
            n_tests++;
            if (irq_valid[c] != e_v[c] || (e_v[c] && (aid != e_id[c] || ap != e_pr[c]))) begin
               n_fail++;
               $display("FAIL %s model cpu%0d: actual v=%0d id=%0d p=%0h expected v=%0d id=%0d p=%0h",
                        cur_req, c, irq_valid[c], aid, ap, e_v[c], e_id[c], e_pr[c]);
            end
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R12 encoding: kind 0 global, 1 enable, 2 priority, 3 routing
   task automatic cfg(input int kind, input int id, input int data);
      cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_id = IW'(id); cfg_wdata = PW'(data);
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic sgi(input int id, input int cpus);
      sgi_req = 1'b1; sgi_id = 4'(id); sgi_cpus = NC'(cpus);
      tick(1);
      sgi_req = 1'b0; sgi_cpus = '0;
   endtask

   task automatic do_ack(input int mask);
      ack = NC'(mask);
      tick(1);
      ack = '0;
   endtask

   task automatic do_eoi(input int c, input int id);
      eoi[c] = 1'b1; eoi_id[c*IW +: IW] = IW'(id);
      tick(1);
      eoi = '0;
   endtask

   task automatic expect_out(input int c, input bit v, input int id, input int p, input string req);
      int aid, ap;
      aid = int'(irq_id[c*IW +: IW]);
      ap  = int'(irq_prio[c*PW +: PW]);
      n_tests++;
      if (irq_valid[c] != v || (v && (aid != id || ap != p))) begin
         n_fail++;
         $display("FAIL %s cpu%0d: actual v=%0d id=%0d p=%0h expected v=%0d id=%0d p=%0h",
                  req, c, irq_valid[c], aid, ap, v, id, p);
      end
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      cur_req = "R1";
      expect_out(0, 0, 0, 0, "R1");
      expect_out(1, 0, 0, 0, "R1");

      cur_req = "R2";
      cfg(1, 3, 1);
      cfg(2, 3, 8'h40);
      sgi(3, 2'b11);
      tick(1);
      expect_out(0, 0, 0, 0, "R2");
      cfg(0, 0, 1);
      tick(1);
      cur_req = "R5";
      expect_out(0, 1, 3, 8'h40, "R5");
      expect_out(1, 1, 3, 8'h40, "R12");

      cur_req = "R4";
      cfg(1, 5, 1);
      cfg(2, 5, 8'h40);
      sgi(5, 2'b10);
      tick(1);
      expect_out(1, 1, 3, 8'h40, "R4");
      cfg(2, 5, 8'h10);
      tick(1);
      expect_out(1, 1, 5, 8'h10, "R4");
      expect_out(0, 1, 3, 8'h40, "R5");

      cur_req = "R6";
      do_ack(2'b10);
      tick(1);
      expect_out(1, 1, 3, 8'h40, "R10");
      do_ack(2'b01);
      tick(1);
      expect_out(0, 0, 0, 0, "R6");
      expect_out(1, 1, 3, 8'h40, "R6");

      cur_req = "R10";
      sgi(3, 2'b01);
      tick(1);
      expect_out(0, 0, 0, 0, "R10");
      do_eoi(0, 3);
      tick(1);
      expect_out(0, 1, 3, 8'h40, "R10");

      cur_req = "R3";
      cfg(1, 3, 0);
      tick(1);
      expect_out(0, 0, 0, 0, "R3");
      expect_out(1, 0, 0, 0, "R3");
      cfg(1, 3, 1);
      tick(1);
      expect_out(0, 1, 3, 8'h40, "R3");

      cur_req = "R11";
      ack = 2'b01;
      tick(1);
      sgi_req = 1'b1; sgi_id = 4'd3; sgi_cpus = 2'b01;
      tick(1);
      ack = '0; sgi_req = 1'b0; sgi_cpus = '0;
      do_eoi(0, 3);
      tick(1);
      expect_out(0, 1, 3, 8'h40, "R11");
      do_ack(2'b01);
      do_eoi(0, 3);
      do_ack(2'b10);
      do_eoi(1, 3);
      do_eoi(1, 5);
      tick(1);
      expect_out(0, 0, 0, 0, "R11");
      expect_out(1, 0, 0, 0, "R11");

      cur_req = "R7";
      cfg(1, 20, 1);
      cfg(2, 20, 8'h20);
      ppi[1*16 + 4] = 1'b1;
      tick(2);
      expect_out(1, 1, 20, 8'h20, "R7");
      expect_out(0, 0, 0, 0, "R7");
      cur_req = "R10";
      do_ack(2'b10);
      tick(1);
      expect_out(1, 0, 0, 0, "R10");
      tick(3);
      expect_out(1, 0, 0, 0, "R10");
      do_eoi(1, 20);
      tick(2);
      expect_out(1, 1, 20, 8'h20, "R10");
      ppi = '0;
      do_ack(2'b10);
      do_eoi(1, 20);
      tick(1);
      expect_out(1, 0, 0, 0, "R10");

      cur_req = "R8";
      cfg(1, 21, 1);
      cfg(2, 21, 8'h30);
      cfg(3, 21, 2'b11);
      ppi[0*16 + 5] = 1'b1;
      tick(2);
      expect_out(0, 1, 21, 8'h30, "R8");
      expect_out(1, 0, 0, 0, "R8");
      ppi = '0;
      do_ack(2'b01);
      do_eoi(0, 21);
      cfg(1, 41, 1);
      cfg(2, 41, 8'h08);
      cfg(3, 41, 2'b10);
      spi[9] = 1'b1;
      tick(1);
      spi = '0;
      tick(1);
      expect_out(1, 1, 41, 8'h08, "R8");
      expect_out(0, 0, 0, 0, "R8");
      do_ack(2'b10);
      do_eoi(1, 41);
      tick(1);
      expect_out(1, 0, 0, 0, "R8");

      cur_req = "R9";
      cfg(1, 40, 1);
      cfg(2, 40, 8'h08);
      cfg(3, 40, 2'b11);
      spi[8] = 1'b1;
      tick(1);
      spi = '0;
      tick(1);
      expect_out(0, 1, 40, 8'h08, "R9");
      expect_out(1, 1, 40, 8'h08, "R9");
      do_ack(2'b11);
      tick(1);
      expect_out(0, 0, 0, 0, "R9");
      expect_out(1, 0, 0, 0, "R9");
      do_eoi(0, 40);
      spi[8] = 1'b1;
      tick(1);
      spi = '0;
      tick(1);
      expect_out(1, 1, 40, 8'h08, "R9");
      do_ack(2'b01);
      tick(1);
      expect_out(1, 0, 0, 0, "R9");
      expect_out(0, 0, 0, 0, "R9");
      do_eoi(0, 40);

      cur_req = "R4";
      cfg(1, 42, 1); cfg(2, 42, 8'hFE); cfg(3, 42, 2'b01);
      cfg(1, 43, 1); cfg(2, 43, 8'hFF); cfg(3, 43, 2'b01);
      spi[10] = 1'b1; spi[11] = 1'b1;
      tick(1);
      spi = '0;
      tick(1);
      expect_out(0, 1, 42, 8'hFE, "R4");
      do_ack(2'b01);
      tick(1);
      expect_out(0, 1, 43, 8'hFF, "R4");
      do_ack(2'b01);
      do_eoi(0, 42);
      do_eoi(0, 43);
      tick(2);
      expect_out(0, 0, 0, 0, "R4");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule